// File: doc/BRIEF.md
# Constant Off-Time Current Limiter

This block keeps the current of a motor bridge under control by chopping it with a fixed off-time. The load current may rise above the present limit while the bridge legs are driving. When that happens the overcurrent comparator flag goes high. The block accepts the event and raises an inhibit. The inhibit sends the bridge outputs to high impedance for a fixed number of microseconds, and then it releases them without any outside action. A minimum chop period also applies. A new off-time cannot begin until a set number of microseconds has passed since the last one began, so the chopping frequency has an upper bound even when the overcurrent flag stays high.

The block also detects hard shorts. A separate comparator flag reports a short on the high side and another reports a short on the low side. Each leg-activation strobe opens a blanking window. Inside that window the short flags are ignored, so switching spikes and diode recovery spikes do not trip the latch. Outside the window, each short flag requests a latched shutdown on its own output bit.

A digital junction-temperature code (1 °C per LSB) sets the current-limit threshold code. The threshold stays at its nominal value up to a fold-back start temperature. Above that it falls linearly, and an overtemperature latch-off request is raised at the fold-back end temperature. All timing is counted on a one-microsecond tick, which is divided down from the system clock.

Top module: `coff_limiter`

## Requirements
- R1: When `oc_i` is high, no off-time is running and the chop period has expired, `inhibit_o` is 1 from the next cycle. It stays 1 until the OFF_US-th microsecond tick after that and then returns to 0 without outside action.
- R2: An overcurrent flag that arrives while the off-time is running does not restart or extend it.
- R3: A new off-time starts no sooner than PERIOD_US ticks after the previous start, where PERIOD_US is the larger of CHOP_MIN_US and OFF_US. With `oc_i` held high, `inhibit_o` rises once per chop period: 3 rises in 6000 cycles at the default parameters.
- R4: Each `act_i` pulse reloads a blanking window of BLANK_US ticks. The short flags have no effect on `sc_req_o` while the window is open, and also in the cycle of the strobe itself.
- R5: Outside the blanking window, `sc_hs_i` sets `sc_req_o[0]` and `sc_ls_i` sets `sc_req_o[1]` in the next cycle. Each bit is present for every cycle in which its flag is high.
- R6: `lim_code_o` is in 0.1 A units. It is updated one cycle after `temp_i`. It equals LIM_NOM (65) for temp ≤ FOLD_LO_C (160). Between FOLD_LO_C and FOLD_HI_C it equals LIM_NOM − ((dt·S + 128) >> 8), where dt = temp − FOLD_LO_C and S = ⌊(LIM_NOM − LIM_MIN)·256 / (FOLD_HI_C − FOLD_LO_C)⌋, and the result never drops below LIM_MIN (25). At the defaults, 167 °C gives 46.
- R7: For temp ≥ FOLD_HI_C (175), `ot_req_o` is 1 and `lim_code_o` is LIM_MIN one cycle later. Below that temperature `ot_req_o` is 0.
- R8: Synchronous reset clears `inhibit_o`, `sc_req_o` and `ot_req_o`, sets `lim_code_o` to LIM_NOM and clears all timers. The microsecond tick first fires CLK_MHZ cycles after reset is released, and then every CLK_MHZ cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Leg-activation strobe; reloads the blanking window |
| oc_i | input | 1 | Overcurrent comparator flag |
| sc_hs_i | input | 1 | High-side short comparator flag |
| sc_ls_i | input | 1 | Low-side short comparator flag |
| temp_i | input | TEMP_W | Junction temperature code, 1 °C per LSB |
| inhibit_o | output | 1 | Bridge outputs to high impedance (off-time running) |
| sc_req_o | output | 2 | Short latch request: bit 0 high side, bit 1 low side |
| ot_req_o | output | 1 | Overtemperature latch-off request |
| lim_code_o | output | LIM_W | Current-limit threshold code, 0.1 A per LSB |

## Verification
The hardest case to reach is an overcurrent request that arrives after the off-time has ended but while the chop period is still running. Both timers count the same prescaled tick, and the outcome depends on the tick phase at the moment of the request. The stimulus holds `oc_i` high for several chop periods, so a request is waiting at every possible phase. It also sends a second pulse in the middle of an off-time. The blanking mask is driven at its edges as well, with a short flag held across the end of the window and a strobe issued in the same cycle as a short flag.

// File: rtl/coff_pkg.sv
package coff_pkg;
  // width able to hold values 0..maxv
  function automatic int cnt_w(int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/coff_tick.sv
module coff_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  import coff_pkg::*;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = cnt_w(DIV - 1);
      logic [PW-1:0] pc;

      always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else if (pc == PW'(DIV - 1)) pc <= '0;
        else pc <= pc + 1'b1;
      end

      assign tick_o = (pc == PW'(DIV - 1));

      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R8
    end
  endgenerate
endmodule

// File: rtl/coff_timer.sv
module coff_timer #(
  parameter int LOAD = 20,
  parameter int W    = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         load_i,
  output logic [W-1:0] cnt_o,
  output logic         busy_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      cnt_o  <= W'(LOAD);
      busy_o <= (LOAD != 0);
    end else if (tick_i && cnt_o != '0) begin
      cnt_o  <= cnt_o - 1'b1;
      busy_o <= (cnt_o != W'(1));
    end
  end

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R1

  AST_LOAD_VAL: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_o == W'(LOAD))); // R4
endmodule

// File: rtl/coff_fold.sv
module coff_fold #(
  parameter int TEMP_W    = 8,
  parameter int LIM_W     = 8,
  parameter int LIM_NOM   = 65,
  parameter int LIM_MIN   = 25,
  parameter int FOLD_LO_C = 160,
  parameter int FOLD_HI_C = 175
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [LIM_W-1:0]  lim_o,
  output logic              ot_o
);
  localparam int FRAC = 8;
  localparam int SPAN_T = FOLD_HI_C - FOLD_LO_C;
  localparam int SPAN_L = LIM_NOM - LIM_MIN;
  localparam logic [31:0] SLOPE = 32'((SPAN_L << FRAC) / SPAN_T);
  localparam logic [31:0] HALF  = 32'(1 << (FRAC - 1));

  logic [TEMP_W-1:0] dt;
  logic [31:0]       prod, drop;
  logic [LIM_W-1:0]  lim_n;
  logic              hot;

  always_comb begin
    hot  = (temp_i >= TEMP_W'(FOLD_HI_C));
    dt   = (temp_i > TEMP_W'(FOLD_LO_C)) ? (temp_i - TEMP_W'(FOLD_LO_C)) : '0;
    prod = {{(32-TEMP_W){1'b0}}, dt} * SLOPE;
    drop = (prod + HALF) >> FRAC;
    if (hot || drop >= 32'(SPAN_L)) lim_n = LIM_W'(LIM_MIN);
    else                            lim_n = LIM_W'(LIM_NOM) - drop[LIM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_o <= LIM_W'(LIM_NOM);
      ot_o  <= 1'b0;
    end else begin
      lim_o <= lim_n;
      ot_o  <= hot;
    end
  end

  AST_LIM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (lim_o >= LIM_W'(LIM_MIN)) && (lim_o <= LIM_W'(LIM_NOM))); // R6

  AST_OT_MIN: assert property (@(posedge clk) disable iff (rst)
    ot_o |-> (lim_o == LIM_W'(LIM_MIN))); // R7

  AST_COOL_NOM: assert property (@(posedge clk) disable iff (rst)
    (temp_i <= TEMP_W'(FOLD_LO_C)) |=> (lim_o == LIM_W'(LIM_NOM))); // R6
endmodule

// File: rtl/coff_limiter.sv
module coff_limiter #(
  parameter int CLK_MHZ     = 50,
  parameter int OFF_US      = 20,
  parameter int BLANK_US    = 16,
  parameter int CHOP_MIN_US = 50,
  parameter int TEMP_W      = 8,
  parameter int LIM_W       = 8,
  parameter int LIM_NOM     = 65,
  parameter int LIM_MIN     = 25,
  parameter int FOLD_LO_C   = 160,
  parameter int FOLD_HI_C   = 175
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              oc_i,
  input  logic              sc_hs_i,
  input  logic              sc_ls_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              inhibit_o,
  output logic [1:0]        sc_req_o,
  output logic              ot_req_o,
  output logic [LIM_W-1:0]  lim_code_o
);
  import coff_pkg::*;

  localparam int PERIOD_US = imax(CHOP_MIN_US, OFF_US);
  localparam int OFF_W     = cnt_w(OFF_US);
  localparam int PER_W     = cnt_w(PERIOD_US);
  localparam int BLK_W     = cnt_w(BLANK_US);

  logic             us_tick;
  logic             accept;
  logic             off_busy, per_busy, blk_busy;
  logic [OFF_W-1:0] off_cnt;
  logic [PER_W-1:0] per_cnt;
  logic [BLK_W-1:0] blk_cnt;
  logic             sc_open;

  coff_tick #(.DIV(CLK_MHZ)) u_tick (
    .clk(clk), .rst(rst), .tick_o(us_tick)
  );

  // a new off-time needs both the off-time and the chop period finished
  assign accept = oc_i && !off_busy && !per_busy;

  coff_timer #(.LOAD(OFF_US), .W(OFF_W)) u_off (
    .clk(clk), .rst(rst), .tick_i(us_tick), .load_i(accept),
    .cnt_o(off_cnt), .busy_o(off_busy)
  );

  coff_timer #(.LOAD(PERIOD_US), .W(PER_W)) u_per (
    .clk(clk), .rst(rst), .tick_i(us_tick), .load_i(accept),
    .cnt_o(per_cnt), .busy_o(per_busy)
  );

  coff_timer #(.LOAD(BLANK_US), .W(BLK_W)) u_blank (
    .clk(clk), .rst(rst), .tick_i(us_tick), .load_i(act_i),
    .cnt_o(blk_cnt), .busy_o(blk_busy)
  );

  assign inhibit_o = off_busy;

  // short flags pass only outside the blanking window and not on a strobe
  assign sc_open = !blk_busy && !act_i;

  always_ff @(posedge clk) begin
    if (rst) sc_req_o <= 2'b00;
    else     sc_req_o <= {sc_ls_i, sc_hs_i} & {2{sc_open}};
  end

  coff_fold #(
    .TEMP_W(TEMP_W), .LIM_W(LIM_W), .LIM_NOM(LIM_NOM), .LIM_MIN(LIM_MIN),
    .FOLD_LO_C(FOLD_LO_C), .FOLD_HI_C(FOLD_HI_C)
  ) u_fold (
    .clk(clk), .rst(rst), .temp_i(temp_i),
    .lim_o(lim_code_o), .ot_o(ot_req_o)
  );

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (off_cnt != '0 && !us_tick) |=> (off_cnt == $past(off_cnt))); // R2

  AST_PERIOD_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(inhibit_o) |-> ($past(per_cnt) == '0)); // R3

  AST_BLANK_MASK: assert property (@(posedge clk) disable iff (rst)
    (blk_cnt != '0) |=> (sc_req_o == 2'b00)); // R4

  AST_STROBE_MASK: assert property (@(posedge clk) disable iff (rst)
    act_i |=> (sc_req_o == 2'b00)); // R4
endmodule

// File: tb/coff_limiter_bench.sv
module coff_limiter_bench;
  localparam int DIV = 50, OFF = 20, BLANK = 16, PER = 50;
  localparam int NOM = 65, MINL = 25, LO = 160, HI = 175;

  logic clk = 1'b0, rst = 1'b1;
  logic act = 0, oc = 0, hs = 0, ls = 0;
  logic [7:0] temp = 8'd25;
  logic inh, ot;
  logic [1:0] sc;
  logic [7:0] lim;

  always #10 clk = ~clk;

  coff_limiter u_coff_limiter (
    .clk(clk), .rst(rst), .act_i(act), .oc_i(oc), .sc_hs_i(hs), .sc_ls_i(ls),
    .temp_i(temp), .inhibit_o(inh), .sc_req_o(sc), .ot_req_o(ot), .lim_code_o(lim)
  );

  int checks = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input int act_v, input int exp_v, input string tag);
    checks++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic int ref_lim(input int t);
    int s, d;
    s = ((NOM - MINL) * 256) / (HI - LO);
    if (t <= LO) return NOM;
    if (t >= HI) return MINL;
    d = ((t - LO) * s + 128) / 256;
    return (NOM - d < MINL) ? MINL : NOM - d;
  endfunction

  // behavioural reference model, advanced on every rising edge
  int phase = 0, off_rem = 0, per_rem = 0, blk_rem = 0;
  int e_inh = 0, e_sc = 0, e_ot = 0, e_lim = NOM;
  bit model_live = 0;

  always @(posedge clk) begin
    bit tk;
    if (rst) begin
      phase = 0; off_rem = 0; per_rem = 0; blk_rem = 0;
      e_inh = 0; e_sc = 0; e_ot = 0; e_lim = NOM;
    end else begin
      tk = (phase == DIV - 1);
      phase = tk ? 0 : phase + 1;
      e_sc = (blk_rem == 0 && !act) ? {ls, hs} : 0;
      if (oc && off_rem == 0 && per_rem == 0) begin
        off_rem = OFF; per_rem = PER;
      end else if (tk) begin
        if (off_rem > 0) off_rem--;
        if (per_rem > 0) per_rem--;
      end
      if (act) blk_rem = BLANK;
      else if (tk && blk_rem > 0) blk_rem--;
      e_inh = (off_rem != 0);
      e_ot  = (temp >= HI);
      e_lim = ref_lim(temp);
    end
    model_live = 1;
  end

  always @(negedge clk) begin
    if (model_live && !finished) begin
      chk(inh, e_inh, "R1/R2/R3 inhibit");
      chk(sc,  e_sc,  "R4/R5 short request");
      chk(ot,  e_ot,  "R7 overtemp request");
      chk(lim, e_lim, "R6 limit code");
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    bad++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n, rises;
    logic prev;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(inh, 0, "R8 reset inhibit");
    chk(sc, 0, "R8 reset short");
    chk(lim, NOM, "R8 reset limit");

    // single overcurrent pulse, a second pulse inside the off-time
    oc = 1; @(negedge clk); oc = 0;
    n = 0;
    for (int i = 0; i < 1200; i++) begin
      if (i == 300) oc = 1;
      if (i == 301) oc = 0;
      if (inh) n++;
      @(negedge clk);
    end
    chk(int'(n >= (OFF - 1) * DIV + 1 && n <= OFF * DIV), 1, "R1/R2 off-time length");
    chk(inh, 0, "R1 auto release");

    repeat (3000) @(negedge clk);
    // held overcurrent: chop period bound
    oc = 1; rises = 0; prev = inh;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (inh && !prev) rises++;
      prev = inh;
    end
    oc = 0;
    chk(rises, 3, "R3 chop rises");
    repeat (3000) @(negedge clk);

    // blanking window
    act = 1; @(negedge clk); act = 0;
    hs = 1; n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sc != 0) n++;
    end
    chk(n, 0, "R4 short masked in window");
    repeat (800) @(negedge clk);
    chk(sc, 1, "R5 high-side request");
    hs = 0; ls = 1; @(negedge clk); @(negedge clk);
    chk(sc, 2, "R5 low-side request");
    ls = 0; @(negedge clk);
    hs = 1; act = 1; @(negedge clk);
    chk(sc, 0, "R4 strobe same cycle");
    act = 0; hs = 0;
    repeat (900) @(negedge clk);

    // temperature fold-back
    temp = 8'd160; @(negedge clk); chk(lim, 65, "R6 at fold start");
    temp = 8'd167; @(negedge clk); chk(lim, 46, "R6 mid fold");
    temp = 8'd175; @(negedge clk); chk(lim, 25, "R7 limit at end");
    chk(ot, 1, "R7 overtemp raised");
    temp = 8'd0; @(negedge clk); chk(lim, 65, "R6 cold");
    for (int t = 140; t < 200; t++) begin
      temp = 8'(t);
      repeat (2) @(negedge clk);
    end
    temp = 8'd25;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule